// File: doc/BRIEF.md
# Superimposition Key Signal Generator

This block produces the per-pixel key signal that tells a downstream video mixer whether to show the graphics plane (key high) or let the underlying video through (key low). Each dot it receives the 12-bit colour of the current pixel from the colour lookup stage, the border colour, a programmable chroma key colour and a qualifier that marks active display pixels. A 2-bit compare selector picks one of three behaviours: no comparison, comparison against the border colour (used only while that border is black), or comparison against the chroma key colour. Whenever no comparison applies, a separate control bit sets a full-screen fallback level.

The decision is registered on each dot-clock enable. It then passes through a delay line whose tap is chosen by a 5-bit phase value. This lets the key line up with the video path, which may have more pipeline stages. While the superimpose-enable input is low, the key is forced to the display level.

Colours are packed as {R[3:0], G[3:0], B[3:0]} in bits 11:8, 7:4 and 3:0.

Top module: `superimpose_key_gen`

## Requirements
- R1: After reset is asserted, ys_o is low until the first decision is registered.
- R2: When son_i is low, the registered key is high, whatever the other inputs are.
- R3: With son_i high and cmp_sel_i = 2'b00 or 2'b01, the key equals fb_hi_i (1 = display, 0 = transparent).
- R4: With son_i high, cmp_sel_i = 2'b10, disp_en_i high and border_rgb_i = 12'h000, the key is high when pix_rgb_i differs from 12'h000 and low when it equals it.
- R5: With cmp_sel_i = 2'b10 and a non-black border_rgb_i, the key equals fb_hi_i.
- R6: With son_i high, cmp_sel_i = 2'b11 and disp_en_i high, the key is low only when all 12 bits of pix_rgb_i equal key_rgb_i. A mismatch in any single channel makes it high.
- R7: With son_i high and disp_en_i low, the key equals fb_hi_i in every compare mode.
- R8: The decision register and the delay line advance only on cycles with dot_en_i high. On other cycles ys_o holds its value.
- R9: With phase_i = 0, a decision appears on ys_o after the dot_en_i edge that samples it. With phase_i = p (1 to 31), it appears p dot_en_i strobes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dot_en_i | input | 1 | Dot-clock enable strobe |
| son_i | input | 1 | Superimpose enable; low forces the display level |
| cmp_sel_i | input | 2 | Compare mode: 00 none, 01 none, 10 border, 11 chroma key |
| fb_hi_i | input | 1 | Fallback level when no comparison applies |
| disp_en_i | input | 1 | Active display pixel qualifier |
| pix_rgb_i | input | 12 | Current pixel colour {R,G,B} |
| border_rgb_i | input | 12 | Border colour {R,G,B} |
| key_rgb_i | input | 12 | Chroma key colour {R,G,B} |
| phase_i | input | 5 | Key delay in dot strobes |
| ys_o | output | 1 | Superimposition key (1 display, 0 transparent) |

## Verification
With phase_i at zero and dot_en_i held high, each decision is due on ys_o one clock after its inputs are applied. The bench drives every vector on a falling edge and samples on the next falling edge. For a non-zero phase p, the bench first flushes the line with a settled level and then flips the decision. It confirms the old level is still present after p strobes and the new level after p+1. The hold behaviour is checked by lowering dot_en_i, changing inputs over several cycles, and sampling ys_o before and after one renewed strobe.

// File: rtl/skey_pkg.sv
package skey_pkg;
  localparam int unsigned CH_W  = 4;
  localparam int unsigned RGB_W = 3 * CH_W;

  typedef enum logic [1:0] {
    CMP_NONE   = 2'b00,
    CMP_SPARE  = 2'b01,
    CMP_BORDER = 2'b10,
    CMP_KEY    = 2'b11
  } cmp_mode_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/skey_decide.sv
module skey_decide
  import skey_pkg::*;
(
  input  logic      son_i,
  input  cmp_mode_e mode_i,
  input  logic      fb_hi_i,
  input  logic      disp_en_i,
  input  rgb_t      pix_i,
  input  rgb_t      border_i,
  input  rgb_t      key_i,
  output logic      ys_next_o
);
  logic [2:0] eq_key, eq_border, border_zero;
  logic [CH_W-1:0] pix_ch [3];
  logic [CH_W-1:0] key_ch [3];
  logic [CH_W-1:0] bor_ch [3];

  assign pix_ch[0] = pix_i.r;    assign pix_ch[1] = pix_i.g;    assign pix_ch[2] = pix_i.b;
  assign key_ch[0] = key_i.r;    assign key_ch[1] = key_i.g;    assign key_ch[2] = key_i.b;
  assign bor_ch[0] = border_i.r; assign bor_ch[1] = border_i.g; assign bor_ch[2] = border_i.b;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    assign eq_key[c]      = (pix_ch[c] == key_ch[c]);
    assign eq_border[c]   = (pix_ch[c] == bor_ch[c]);
    assign border_zero[c] = (bor_ch[c] == '0);
  end

  always_comb begin
    ys_next_o = fb_hi_i;
    if (!son_i) begin
      ys_next_o = 1'b1;
    end else if (disp_en_i) begin
      unique case (mode_i)
        CMP_KEY:    ys_next_o = ~&eq_key;
        CMP_BORDER: if (&border_zero) ys_next_o = ~&eq_border;
        default:    ys_next_o = fb_hi_i;
      endcase
    end
  end
endmodule

// File: rtl/skey_delay.sv
module skey_delay #(
  parameter int unsigned DLY_MAX = 31,
  localparam int unsigned PH_W   = $clog2(DLY_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            din_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            tap_o
);
  logic [DLY_MAX-1:0] line_q;

  for (genvar i = 0; i < DLY_MAX; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   line_q[i] <= 1'b0;
      else if (en_i) line_q[i] <= (i == 0) ? din_i : line_q[(i == 0) ? 0 : i-1];
    end
  end

  always_comb begin
    if (phase_i == '0)                      tap_o = din_i;
    else if (int'(phase_i) > int'(DLY_MAX)) tap_o = line_q[DLY_MAX-1];
    else                                    tap_o = line_q[int'(phase_i) - 1];
  end

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $stable(din_i)) |=> ($stable(tap_o) || !$stable(phase_i)));

  // R9
  one_stage_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && phase_i == 1) |=> (phase_i != 1 || tap_o == $past(din_i)));
endmodule

// File: rtl/superimpose_key_gen.sv
module superimpose_key_gen
  import skey_pkg::*;
#(
  parameter int unsigned DLY_MAX = 31,
  localparam int unsigned PH_W   = $clog2(DLY_MAX + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dot_en_i,
  input  logic            son_i,
  input  logic [1:0]      cmp_sel_i,
  input  logic            fb_hi_i,
  input  logic            disp_en_i,
  input  logic [11:0]     pix_rgb_i,
  input  logic [11:0]     border_rgb_i,
  input  logic [11:0]     key_rgb_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            ys_o
);
  logic ys_next, ys_raw_q;

  skey_decide u_decide (
    .son_i     (son_i),
    .mode_i    (cmp_mode_e'(cmp_sel_i)),
    .fb_hi_i   (fb_hi_i),
    .disp_en_i (disp_en_i),
    .pix_i     (rgb_t'(pix_rgb_i)),
    .border_i  (rgb_t'(border_rgb_i)),
    .key_i     (rgb_t'(key_rgb_i)),
    .ys_next_o (ys_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ys_raw_q <= 1'b0;
    else if (dot_en_i) ys_raw_q <= ys_next;
  end

  skey_delay #(.DLY_MAX(DLY_MAX)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (dot_en_i),
    .din_i   (ys_raw_q),
    .phase_i (phase_i),
    .tap_o   (ys_o)
  );

  // R2
  son_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && !son_i) |=> ys_raw_q);

  // R6
  key_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && son_i && disp_en_i && cmp_sel_i == 2'b11 && pix_rgb_i == key_rgb_i)
      |=> !ys_raw_q);

  // R3
  fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dot_en_i && son_i && !cmp_sel_i[1]) |=> (ys_raw_q == $past(fb_hi_i)));

  // R8
  raw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dot_en_i |=> $stable(ys_raw_q));
endmodule

// File: tb/superimpose_key_gen_bench.sv
module superimpose_key_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dot_en = 1'b0, son = 1'b0, fb = 1'b0, disp = 1'b0;
  logic [1:0] sel = '0;
  logic [11:0] pix = '0, bor = '0, key = '0;
  logic [4:0] phase = '0;
  logic ys;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  superimpose_key_gen u_superimpose_key_gen (
    .clk_i(clk), .rst_ni(rst_n), .dot_en_i(dot_en), .son_i(son),
    .cmp_sel_i(sel), .fb_hi_i(fb), .disp_en_i(disp), .pix_rgb_i(pix),
    .border_rgb_i(bor), .key_rgb_i(key), .phase_i(phase), .ys_o(ys));

  // {son, sel, fb, disp, pix, border, key, expected, req}
  localparam int NV = 19;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 2'b11, 1'b0, 1'b1, 12'h123, 12'h000, 12'h123, 1'b1, 4'd2}, // R2
    {1'b0, 2'b00, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, 4'd2}, // R2
    {1'b1, 2'b00, 1'b0, 1'b1, 12'h5A5, 12'h000, 12'h000, 1'b0, 4'd3}, // R3
    {1'b1, 2'b00, 1'b1, 1'b1, 12'h5A5, 12'h000, 12'h000, 1'b1, 4'd3}, // R3
    {1'b1, 2'b01, 1'b0, 1'b1, 12'h5A5, 12'h000, 12'h5A5, 1'b0, 4'd3}, // R3
    {1'b1, 2'b01, 1'b1, 1'b1, 12'h000, 12'h000, 12'h000, 1'b1, 4'd3}, // R3
    {1'b1, 2'b10, 1'b0, 1'b1, 12'h000, 12'h000, 12'h000, 1'b0, 4'd4}, // R4
    {1'b1, 2'b10, 1'b0, 1'b1, 12'h001, 12'h000, 12'h000, 1'b1, 4'd4}, // R4
    {1'b1, 2'b10, 1'b1, 1'b1, 12'h000, 12'h000, 12'h000, 1'b0, 4'd4}, // R4
    {1'b1, 2'b10, 1'b0, 1'b1, 12'h800, 12'h000, 12'h000, 1'b1, 4'd4}, // R4
    {1'b1, 2'b10, 1'b0, 1'b1, 12'h000, 12'h100, 12'h000, 1'b0, 4'd5}, // R5
    {1'b1, 2'b10, 1'b1, 1'b1, 12'h000, 12'h010, 12'h000, 1'b1, 4'd5}, // R5
    {1'b1, 2'b11, 1'b1, 1'b1, 12'h3C7, 12'h000, 12'h3C7, 1'b0, 4'd6}, // R6
    {1'b1, 2'b11, 1'b0, 1'b1, 12'h3C6, 12'h000, 12'h3C7, 1'b1, 4'd6}, // R6
    {1'b1, 2'b11, 1'b0, 1'b1, 12'h2C7, 12'h000, 12'h3C7, 1'b1, 4'd6}, // R6
    {1'b1, 2'b11, 1'b0, 1'b1, 12'h3D7, 12'h000, 12'h3C7, 1'b1, 4'd6}, // R6
    {1'b1, 2'b11, 1'b0, 1'b0, 12'h3C6, 12'h000, 12'h3C7, 1'b0, 4'd7}, // R7
    {1'b1, 2'b11, 1'b1, 1'b0, 12'h3C7, 12'h000, 12'h3C7, 1'b1, 4'd7}, // R7
    {1'b1, 2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, 4'd7}  // R7
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (ys !== exp) begin
      fails++;
      $display("FAIL %s ys_o=%b expected=%b", req, ys, exp);
    end
  endtask

  task automatic apply(input logic [45:0] v);
    {son, sel, fb, disp, pix, bor, key} = v[45:5];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    dot_en = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      @(negedge clk);
      check(VEC[i][4], $sformatf("R%0d vec%0d", VEC[i][3:0], i));
    end

    // R8: hold while dot_en low
    apply(VEC[3]);
    @(negedge clk);
    check(1'b1, "R8 pre");
    dot_en = 1'b0;
    apply(VEC[2]);
    repeat (3) @(negedge clk);
    check(1'b1, "R8 held");
    son = 1'b0;
    @(negedge clk);
    check(1'b1, "R8 held");
    son = 1'b1;
    dot_en = 1'b1;
    @(negedge clk);
    check(1'b0, "R8 resume");

    // R9: delay by phase
    foreach (VEC[k]) if (k < 1) begin end
    for (int t = 0; t < 4; t++) begin
      int p;
      p = (t == 0) ? 1 : (t == 1) ? 5 : (t == 2) ? 17 : 31;
      phase = 5'(p);
      son = 1'b1; sel = 2'b00; fb = 1'b0; disp = 1'b1;
      repeat (40) @(negedge clk);
      check(1'b0, "R9 settled");
      fb = 1'b1;
      repeat (p) @(negedge clk);
      check(1'b0, $sformatf("R9 phase %0d early", p));
      @(negedge clk);
      check(1'b1, $sformatf("R9 phase %0d due", p));
    end

    // R1: reset clears a loaded line
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R1 re-reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule